// File: doc/BRIEF.md
# Parallel Canberra Distance Engine

This block measures how far one test feature vector lies from every vector of a training set. The distance it uses is the Canberra form: for each feature, the absolute difference of the two values is divided by their sum, and these ratios are added up. Features are unsigned fractions in [0, 1]. They arrive on a valid/ready input stream, eight to a beat. Eight lanes each compute one ratio in every beat, so a vector of 160 features takes 20 beats. A shared accumulator gathers the eight lane terms beat by beat.

A set begins with one test vector. The engine keeps it in an internal register file. The training vectors then follow one after another. When the last beat of a training vector has passed through the divider pipeline, the engine puts its total distance and its training index on a valid/ready output stream. That stream can feed a sorting stage directly. The last distance of a set carries a last flag. The engine then waits for the test vector of the next set.

Back-pressure rules are as follows. An input beat is taken on any rising clock edge where `in_valid` and `in_ready` are both high. While `in_valid` is high and `in_ready` is low, the source must hold `in_data` steady. An output beat is delivered on any edge where `out_valid` and `out_ready` are both high. While it waits, the output holds all of its fields. `in_ready` goes low only when the output is stalled, that is, when `out_valid` is high and `out_ready` is low. The path from `out_ready` to `in_ready` is purely combinational. The input side is never throttled for any other reason.

Top module: `cdist_engine`

## Requirements
- R1: Each feature term is floor(|u−v|·2^16/(u+v)) as an unsigned 16-bit value, and a term whose sum u+v is zero is 0. The distance output is the sum of all terms of the vector.
- R2: When exactly one of u and v is zero, the quotient is 1.0. That value does not fit in Q0.16, so the term saturates to 0xFFFF.
- R3: After reset, and after the last vector of each set, the first NUM_FEAT/LANES accepted beats load the test vector. Later beats are training features. In beat b, lane k occupies `in_data[16k+15:16k]` and carries feature b·LANES+k.
- R4: Exactly one output beat is produced per training vector. The indices run 0, 1, 2 … NUM_VEC−1 in arrival order.
- R5: `out_last` is 1 only on the output of training vector NUM_VEC−1. The next accepted beats then form a fresh test vector.
- R6: While `out_valid` is 1 and `out_ready` is 0, the output fields stay unchanged and `in_ready` is 0.
- R7: Reset clears all pending work. `out_valid` reads 0, `in_ready` reads 1, and the engine expects a test vector.
- R8: The accumulator restarts for each training vector. A training vector equal to the test vector yields distance 0, even when it directly follows a vector with a large distance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Engine accepts the beat on this edge |
| in_data | input | 128 | Eight Q0.16 features, lane k at bits 16k+15:16k |
| out_valid | output | 1 | Distance result present |
| out_ready | input | 1 | Sink takes the result on this edge |
| out_dist | output | 24 | Canberra distance in Q8.16 |
| out_idx | output | 10 | Index of the training vector within the set |
| out_last | output | 1 | Result of the final training vector in the set |

## Verification
A divider stage that drops or misplaces a quotient bit shows up as a wrong `out_dist`, 17 cycles after the last beat of the affected vector. A lane that mishandles the zero-sum or the one-zero case shows up only in vectors that contain zeros, so the stimulus includes them next to a test vector with zeros in lane 0. A beat counter or phase register that slips sends training data into the test register file. That fault corrupts every later distance and also disturbs the index sequence and the position of `out_last`. These are checked on every output beat. A reset in the middle of a set, followed by a full set, shows whether the phase state really returns to loading the test vector. A stalled output must hold its fields and pull `in_ready` low at once, and both are sampled in the same cycle as the stall.

// File: rtl/cdist_pkg.sv
package cdist_pkg;

  typedef enum logic {
    PH_LOAD  = 1'b0,
    PH_TRAIN = 1'b1
  } phase_e;

  // Position tags that travel with a beat through the divider pipeline
  typedef struct packed {
    logic first;  // first beat of a training vector
    logic lastb;  // last beat of a training vector
    logic lasts;  // last beat of the last vector of the set
  } mark_t;

endpackage

// File: rtl/cdist_seq.sv
module cdist_seq
  import cdist_pkg::*;
#(
  parameter int BEATS   = 20,
  parameter int NUM_VEC = 1024,
  parameter int BEAT_W  = 5,
  parameter int IDX_W   = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  output phase_e            phase,
  output logic [BEAT_W-1:0] beat,
  output logic [IDX_W-1:0]  vec,
  output mark_t             mark
);

  localparam logic [BEAT_W-1:0] BEAT_END = BEAT_W'(BEATS - 1);
  localparam logic [IDX_W-1:0]  VEC_END  = IDX_W'(NUM_VEC - 1);

  logic at_beat_end;
  assign at_beat_end = (beat == BEAT_END);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_LOAD;
      beat  <= '0;
      vec   <= '0;
    end else if (fire) begin
      if (at_beat_end) begin
        beat <= '0;
        if (phase == PH_LOAD) begin
          phase <= PH_TRAIN;
          vec   <= '0;
        end else if (vec == VEC_END) begin
          phase <= PH_LOAD;
          vec   <= '0;
        end else begin
          vec <= vec + 1'b1;
        end
      end else begin
        beat <= beat + 1'b1;
      end
    end
  end

  always_comb begin
    mark.first = (beat == '0);
    mark.lastb = at_beat_end;
    mark.lasts = at_beat_end && (vec == VEC_END);
  end

  // R3
  beat_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat <= BEAT_END);

  // R3
  vec_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_LOAD) |-> (vec == '0));

endmodule

// File: rtl/cdist_tstore.sv
module cdist_tstore #(
  parameter int BEATS  = 20,
  parameter int VW     = 128,
  parameter int BEAT_W = 5
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [BEAT_W-1:0] addr,
  input  logic [VW-1:0]     wdata,
  output logic [VW-1:0]     rdata
);

  logic [VW-1:0] rows [BEATS];

  always_ff @(posedge clk) begin
    if (wr_en) rows[addr] <= wdata;
  end

  assign rdata = rows[addr];

endmodule

// File: rtl/cdist_lane.sv
module cdist_lane #(
  parameter int FW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic          in_vld,
  input  logic [FW-1:0] u,
  input  logic [FW-1:0] v,
  output logic          out_vld,
  output logic [FW-1:0] term
);

  // Stage 0 holds the prepared operands, and each later stage resolves one quotient bit
  logic [FW:0]   rem [0:FW];
  logic [FW:0]   den [0:FW];
  logic [FW-1:0] quo [0:FW];
  logic          sat [0:FW];
  logic          zer [0:FW];
  logic          vld [0:FW];
  logic [FW+1:0] sub [1:FW];

  logic [FW-1:0] diff;
  logic [FW:0]   total;

  always_comb begin
    diff  = (u > v) ? (u - v) : (v - u);
    total = {1'b0, u} + {1'b0, v};
  end

  always_comb begin
    for (int s = 1; s <= FW; s++) begin
      sub[s] = {rem[s-1], 1'b0} - {1'b0, den[s-1]};
    end
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      rem[0] <= {1'b0, diff};
      den[0] <= total;
      quo[0] <= '0;
      zer[0] <= (total == '0);
      sat[0] <= (total != '0) && ({1'b0, diff} == total);
      for (int s = 1; s <= FW; s++) begin
        rem[s] <= sub[s][FW+1] ? {rem[s-1][FW-1:0], 1'b0} : sub[s][FW:0];
        quo[s] <= {quo[s-1][FW-2:0], ~sub[s][FW+1]};
        den[s] <= den[s-1];
        sat[s] <= sat[s-1];
        zer[s] <= zer[s-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s <= FW; s++) vld[s] <= 1'b0;
    end else if (adv) begin
      vld[0] <= in_vld;
      for (int s = 1; s <= FW; s++) vld[s] <= vld[s-1];
    end
  end

  assign out_vld = vld[FW];
  assign term    = zer[FW] ? '0 : (sat[FW] ? '1 : quo[FW]);

  for (genvar s = 0; s <= FW; s++) begin : g_chk
    // R1
    rem_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vld[s] && !sat[s] && !zer[s]) |-> (rem[s] < den[s]));
  end

  // R2
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld[FW] |-> !(sat[FW] && zer[FW]));

endmodule

// File: rtl/cdist_acc.sv
module cdist_acc
  import cdist_pkg::*;
#(
  parameter int LANES    = 8,
  parameter int FW       = 16,
  parameter int ACC_W    = 24,
  parameter int IDX_W    = 10,
  parameter int NUM_VEC  = 1024,
  parameter int NUM_FEAT = 160
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tag_vld,
  input  mark_t               tag_mark,
  input  logic [IDX_W-1:0]    tag_idx,
  input  logic [LANES*FW-1:0] terms,
  output logic                adv,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [ACC_W-1:0]    out_dist,
  output logic [IDX_W-1:0]    out_idx,
  output logic                out_last
);

  localparam int     SUM_W   = FW + $clog2(LANES + 1);
  localparam longint ACC_MAX = longint'(NUM_FEAT) * ((longint'(1) << FW) - 1);

  logic [SUM_W-1:0] beat_sum;
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] acc_next;

  always_comb begin
    beat_sum = '0;
    for (int k = 0; k < LANES; k++) begin
      beat_sum = beat_sum + SUM_W'(terms[k*FW +: FW]);
    end
    acc_next = (tag_mark.first ? '0 : acc_q) + ACC_W'(beat_sum);
  end

  assign adv = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q     <= '0;
      out_valid <= 1'b0;
      out_dist  <= '0;
      out_idx   <= '0;
      out_last  <= 1'b0;
    end else begin
      if (out_ready) out_valid <= 1'b0;
      if (adv && tag_vld) begin
        acc_q <= acc_next;
        if (tag_mark.lastb) begin
          out_valid <= 1'b1;
          out_dist  <= acc_next;
          out_idx   <= tag_idx;
          out_last  <= tag_mark.lasts;
        end
      end
    end
  end

  // Index the next delivered result must carry
  logic [IDX_W-1:0] want_idx;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) want_idx <= '0;
    else if (out_valid && out_ready) want_idx <= out_last ? '0 : out_idx + 1'b1;
  end

  // R4
  idx_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_idx == want_idx));

  // R5
  last_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_last) |-> (out_idx == IDX_W'(NUM_VEC - 1)));

  // R6
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_dist)
                                   && $stable(out_idx) && $stable(out_last)));

  // R1
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    longint'(acc_q) <= ACC_MAX);

endmodule

// File: rtl/cdist_engine.sv
module cdist_engine
  import cdist_pkg::*;
#(
  parameter  int FW       = 16,
  parameter  int LANES    = 8,
  parameter  int NUM_FEAT = 160,
  parameter  int NUM_VEC  = 1024,
  parameter  int ACC_W    = 24,
  localparam int IDX_W    = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1,
  localparam int VW       = LANES * FW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [VW-1:0]    in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [ACC_W-1:0] out_dist,
  output logic [IDX_W-1:0] out_idx,
  output logic             out_last
);

  localparam int BEATS  = NUM_FEAT / LANES;
  localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1;

  logic              adv;
  logic              fire;
  phase_e            phase;
  logic [BEAT_W-1:0] beat;
  logic [IDX_W-1:0]  vec;
  mark_t             mark;
  logic [VW-1:0]     test_row;
  logic [VW-1:0]     terms;
  logic [LANES-1:0]  lane_vld;

  assign in_ready = adv;
  assign fire     = in_valid && adv;

  cdist_seq #(
    .BEATS(BEATS), .NUM_VEC(NUM_VEC), .BEAT_W(BEAT_W), .IDX_W(IDX_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .fire(fire),
    .phase(phase), .beat(beat), .vec(vec), .mark(mark)
  );

  cdist_tstore #(
    .BEATS(BEATS), .VW(VW), .BEAT_W(BEAT_W)
  ) u_tstore (
    .clk(clk), .wr_en(fire && (phase == PH_LOAD)), .addr(beat),
    .wdata(in_data), .rdata(test_row)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    cdist_lane #(.FW(FW)) u_lane (
      .clk(clk), .rst_n(rst_n), .adv(adv),
      .in_vld(fire && (phase == PH_TRAIN)),
      .u(test_row[k*FW +: FW]), .v(in_data[k*FW +: FW]),
      .out_vld(lane_vld[k]), .term(terms[k*FW +: FW])
    );
  end

  // Tag pipeline, the same depth as the lane divider
  logic             tg_vld  [0:FW];
  mark_t            tg_mark [0:FW];
  logic [IDX_W-1:0] tg_idx  [0:FW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s <= FW; s++) tg_vld[s] <= 1'b0;
    end else if (adv) begin
      tg_vld[0] <= fire && (phase == PH_TRAIN);
      for (int s = 1; s <= FW; s++) tg_vld[s] <= tg_vld[s-1];
    end
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      tg_mark[0] <= mark;
      tg_idx[0]  <= vec;
      for (int s = 1; s <= FW; s++) begin
        tg_mark[s] <= tg_mark[s-1];
        tg_idx[s]  <= tg_idx[s-1];
      end
    end
  end

  cdist_acc #(
    .LANES(LANES), .FW(FW), .ACC_W(ACC_W), .IDX_W(IDX_W),
    .NUM_VEC(NUM_VEC), .NUM_FEAT(NUM_FEAT)
  ) u_acc (
    .clk(clk), .rst_n(rst_n),
    .tag_vld(tg_vld[FW]), .tag_mark(tg_mark[FW]), .tag_idx(tg_idx[FW]),
    .terms(terms), .adv(adv),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_dist(out_dist), .out_idx(out_idx), .out_last(out_last)
  );

  // R1
  lane_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lane_vld == {LANES{tg_vld[FW]}});

  // R6
  stall_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> $stable(beat) && $stable(phase));

endmodule

// File: tb/cdist_engine_test.sv
module cdist_engine_test;

  localparam int FW    = 16;
  localparam int LANES = 8;
  localparam int NF    = 32;
  localparam int NV    = 6;
  localparam int ACC_W = 24;
  localparam int BEATS = NF / LANES;
  localparam int VW    = LANES * FW;
  localparam int IW    = $clog2(NV);

  // Training vector recipe per index: {mode[3:0], base[15:0]}
  // mode 0 ramp, 1 copy of test, 2 all zero, 3 all full scale, 4 alternating
  localparam logic [19:0] VEC_TAB [NV] = '{
    {4'd0, 16'd1000}, {4'd1, 16'd0}, {4'd2, 16'd0},
    {4'd4, 16'h1234}, {4'd3, 16'd0}, {4'd0, 16'd40000}
  };

  logic             clk = 1'b0;
  logic             rst_n;
  logic             in_valid;
  logic             in_ready;
  logic [VW-1:0]    in_data;
  logic             out_valid;
  logic             out_ready;
  logic [ACC_W-1:0] out_dist;
  logic [IW-1:0]    out_idx;
  logic             out_last;

  always #5 clk = ~clk;

  cdist_engine #(
    .FW(FW), .LANES(LANES), .NUM_FEAT(NF), .NUM_VEC(NV), .ACC_W(ACC_W)
  ) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_dist(out_dist), .out_idx(out_idx), .out_last(out_last)
  );

  int nchk = 0;
  int nfail = 0;
  bit done = 0;
  bit stall_mode = 0;
  int exp_dist [64];
  int exp_idx  [64];
  bit exp_last [64];
  int exp_mode [64];
  int wr_p = 0;
  int rd_p = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic int tfeat(input int seed, input int i);
    if (i % 8 == 0) return 0;
    return (i * 2311 + 977 + seed * 4099) % 65536;
  endfunction

  function automatic int vfeat(input int mode, input int base, input int seed, input int i);
    case (mode)
      0: return (base + i * 523) % 65536;
      1: return tfeat(seed, i);
      2: return 0;
      3: return 65535;
      4: return (i % 2 == 1) ? base : 65535 - base;
      default: return 0;
    endcase
  endfunction

  function automatic int term(input int u, input int v);
    longint s, d, q;
    s = longint'(u) + longint'(v);
    if (s == 0) return 0;
    d = (u > v) ? longint'(u - v) : longint'(v - u);
    q = (d * 65536) / s;
    if (q > 65535) q = 65535;
    return int'(q);
  endfunction

  task automatic send_beat(input logic [VW-1:0] d);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = d;
    #2;
    while (!in_ready) begin
      @(negedge clk);
      #2;
    end
  endtask

  task automatic send_set(input int seed, input int nvec);
    logic [VW-1:0] d;
    int acc, mode, base, v, i;
    for (int b = 0; b < BEATS; b++) begin
      for (int k = 0; k < LANES; k++) d[k*FW +: FW] = FW'(tfeat(seed, b*LANES + k));
      send_beat(d);
    end
    for (int n = 0; n < nvec; n++) begin
      mode = int'(VEC_TAB[n][19:16]);
      base = int'(VEC_TAB[n][15:0]);
      acc  = 0;
      for (int b = 0; b < BEATS; b++) begin
        for (int k = 0; k < LANES; k++) begin
          i = b*LANES + k;
          v = vfeat(mode, base, seed, i);
          acc += term(tfeat(seed, i), v);
          d[k*FW +: FW] = FW'(v);
        end
        send_beat(d);
      end
      if (nvec == NV) begin
        exp_dist[wr_p] = acc;
        exp_idx[wr_p]  = n;
        exp_last[wr_p] = (n == NV - 1);
        exp_mode[wr_p] = mode;
        wr_p++;
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic drain();
    for (int t = 0; t < 400 && rd_p < wr_p; t++) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  // Output monitor: drives out_ready and checks every delivered result
  int cyc = 0;
  bit held = 0;
  logic [ACC_W-1:0] h_dist;
  logic [IW-1:0]    h_idx;
  logic             h_last;
  string tag;

  initial begin
    out_ready = 1'b1;
    forever begin
      @(negedge clk);
      out_ready = stall_mode ? (cyc % 3 != 0) : 1'b1;
      cyc++;
      #1;
      if (!rst_n) begin
        held = 0;
      end else begin
        if (held) begin
          chk(out_valid && out_dist == h_dist && out_idx == h_idx && out_last == h_last,
              "R6 held output changed", int'(out_dist), int'(h_dist));
          held = 0;
        end
        if (out_valid && !out_ready) begin
          chk(!in_ready, "R6 in_ready during stall", int'(in_ready), 0);
          held   = 1;
          h_dist = out_dist;
          h_idx  = out_idx;
          h_last = out_last;
        end else if (out_valid && out_ready) begin
          if (rd_p >= wr_p) begin
            chk(1'b0, "R4 unexpected output", int'(out_idx), -1);
          end else begin
            case (exp_mode[rd_p])
              1: tag = "R8 identical vector distance";
              2, 3: tag = "R2 saturating term distance";
              default: tag = "R1 R3 distance";
            endcase
            chk(int'(out_dist) == exp_dist[rd_p], tag, int'(out_dist), exp_dist[rd_p]);
            chk(int'(out_idx) == exp_idx[rd_p], "R4 index", int'(out_idx), exp_idx[rd_p]);
            chk(out_last == exp_last[rd_p], "R5 last flag", int'(out_last), int'(exp_last[rd_p]));
            rd_p++;
          end
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nfail++;
      nchk++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", rd_p, 2*NV);
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_data  = '0;
    repeat (3) @(negedge clk);
    #3;
    chk(!out_valid, "R7 out_valid in reset", int'(out_valid), 0);
    chk(in_ready, "R7 in_ready in reset", int'(in_ready), 1);
    @(negedge clk);
    rst_n = 1'b1;

    // Abandon a set part way, then reset
    send_set(5, 2);
    repeat (5) @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    #3;
    chk(!out_valid, "R7 out_valid after mid-set reset", int'(out_valid), 0);
    chk(in_ready, "R7 in_ready after mid-set reset", int'(in_ready), 1);
    @(negedge clk);
    rst_n = 1'b1;

    // Full set without back-pressure, then a full set with a fresh test vector under stalls
    send_set(1, NV);
    drain();
    stall_mode = 1;
    send_set(2, NV);
    drain();
    stall_mode = 0;

    chk(rd_p == 2*NV, "R4 R5 result count", rd_p, 2*NV);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

endmodule